// File: doc/BRIEF.md
# Mode Register and Memory-Map Decoder

This block keeps the 16-bit processor mode word and turns its live fields into memory-map decisions. Every program-space address goes to exactly one of three targets: the overlay RAM, the on-chip ROM or external memory. Every data-space address likewise goes to exactly one of the main RAM, the extra RAM blocks or external memory. The same word supplies the page for interrupt vector addresses, gates the output clock, and controls whether the internal program address is shown on the external address output.

A hardware reset loads the mode word. The vector page is set to all ones and the boot-mode bit is taken from the mode pin. A soft reset clears only the low control bits, and leaves the vector page and the boot-mode bit as they are. Software writes the whole word through a simple write port and reads it back in full. The decode paths are combinational, with no handshake and no back-pressure. A select is valid in the same cycle as the address that produces it.

Top module: `mode_map_top`

## Requirements
- R1: While `hw_rst` is high at a rising edge, the word loads as 16'hFF80 with bit 6 equal to `mode_pin`. After that edge, `rd_data` reads 16'hFF80 or 16'hFFC0.
- R2: A write (`wr_en` high at a rising edge) stores `wr_data` into the word. All 16 bits show on `rd_data` from that edge onward.
- R3: A soft reset clears bits 5:0 and keeps bits 15:6. `hw_rst` overrides `soft_rst`, and `soft_rst` overrides a write in the same cycle.
- R4: `mode_pin` has no effect except while `hw_rst` is high. Software can still set or clear bit 6 with a write.
- R5: `pgm_sel` uses bit0 for overlay RAM, bit1 for ROM and bit2 for external. When the address is 16'hC000 or above, bit 6 = 0 selects ROM (bit1) and bit 6 = 1 selects external (bit2).
- R6: When bit 5 is 1, program addresses 16'h0080 to 16'h7FFF select overlay RAM (bit0). Addresses 16'h0000 to 16'h007F never select it. Overlay takes priority over ROM, and ROM takes priority over external.
- R7: `dat_sel` uses bit0 for main RAM, bit1 for extra RAM and bit2 for external. Data addresses 16'h0000 to 16'h7FFF select main RAM. Addresses 16'h8000 to 16'hFFFF select extra RAM when bit 3 is 1, and external when bit 3 is 0.
- R8: `pgm_sel` and `dat_sel` each have exactly one bit set at all times.
- R9: When bit 2 is 1, `clk_out` is held high. When bit 2 is 0, `clk_out` equals `clk`.
- R10: When bit 4 is 1, `ext_addr` takes `pgm_addr` at each rising edge. When bit 4 is 0, it holds its last value. A hardware reset clears it to 0.
- R11: `vec_addr` equals {bits 15:7, `int_num`[4:0], 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| mode_pin | input | 1 | Boot-mode level, sampled only during hardware reset |
| wr_en | input | 1 | Mode word write strobe |
| wr_data | input | 16 | Mode word write value |
| rd_data | output | 16 | Current mode word |
| pgm_addr | input | 16 | Program-space address |
| data_addr | input | 16 | Data-space address |
| pgm_sel | output | 3 | One-hot program target {ext, rom, overlay} |
| dat_sel | output | 3 | One-hot data target {ext, extra RAM, main RAM} |
| int_num | input | 5 | Interrupt number |
| vec_addr | output | 16 | Vector address for `int_num` |
| clk_out | output | 1 | Gated clock output |
| ext_addr | output | 16 | External address output |

## Verification
Register effects from writes, soft resets and hardware resets show on `rd_data` one rising edge after the cycle that requested them. The bench drives each request on a falling edge and reads the result on the next falling edge. The selects and `vec_addr` are combinational, so they are checked 1 ns after the address changes, with no clock edge in between. `ext_addr` registers `pgm_addr` at the rising edge that follows, so it is compared one full cycle later. It is then compared again across several cycles after visibility is turned off. `clk_out` is sampled in the low phase of `clk`, where the gated value and the plain clock can be told apart.

// File: rtl/mode_map_pkg.sv
package mode_map_pkg;
  localparam int WORD_W     = 16;
  localparam int PAGE_BITS  = 7;
  localparam int SLOT_BITS  = 2;
  localparam int VPTR_W     = WORD_W - PAGE_BITS;
  localparam int INT_W      = PAGE_BITS - SLOT_BITS;
  localparam int SEL_W      = 3;

  // Select positions; program and data sides share the same ordering
  localparam int SEL_LOCAL  = 0;  // overlay RAM / main RAM
  localparam int SEL_MID    = 1;  // ROM / extra RAM
  localparam int SEL_EXT    = 2;  // external memory

  typedef struct packed {
    logic [VPTR_W-1:0] vec_page;
    logic              ext_boot;
    logic              ovl_en;
    logic              addr_vis;
    logic              xram_en;
    logic              clk_hold;
    logic              sat_mul;
    logic              sat_store;
  } mode_t;
endpackage

// File: rtl/mode_reg.sv
module mode_reg
  import mode_map_pkg::*;
(
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              soft_rst,
  input  logic              mode_pin,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output mode_t             q
);
  always_ff @(posedge clk) begin
    if (hw_rst) begin
      q          <= '0;
      q.vec_page <= '1;
      q.ext_boot <= mode_pin;
    end else if (soft_rst) begin
      q.ovl_en    <= 1'b0;
      q.addr_vis  <= 1'b0;
      q.xram_en   <= 1'b0;
      q.clk_hold  <= 1'b0;
      q.sat_mul   <= 1'b0;
      q.sat_store <= 1'b0;
    end else if (wr_en) begin
      q <= mode_t'(wr_data);
    end
  end

  // R3
  soft_keep_chk: assert property (@(posedge clk) disable iff (hw_rst)
    soft_rst |=> (q[PAGE_BITS-2:0] == '0) &&
                 (q[WORD_W-1:PAGE_BITS-1] == $past(q[WORD_W-1:PAGE_BITS-1])));

  // R4
  pin_hold_chk: assert property (@(posedge clk) disable iff (hw_rst)
    !wr_en |=> q.ext_boot == $past(q.ext_boot));
endmodule

// File: rtl/prog_decode.sv
module prog_decode
  import mode_map_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hC000,
  parameter logic [ADDR_W-1:0] PAGE0_TOP = 16'h007F,
  parameter logic [ADDR_W-1:0] OVL_TOP   = 16'h7FFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_boot,
  input  logic              ovl_en,
  output logic [SEL_W-1:0]  sel
);
  logic in_ovl, in_rom;

  assign in_ovl = ovl_en && (addr > PAGE0_TOP) && (addr <= OVL_TOP);
  assign in_rom = !ext_boot && (addr >= ROM_BASE);

  always_comb begin
    sel = '0;
    if (in_ovl)      sel[SEL_LOCAL] = 1'b1;
    else if (in_rom) sel[SEL_MID]   = 1'b1;
    else             sel[SEL_EXT]   = 1'b1;
  end
endmodule

// File: rtl/data_decode.sv
module data_decode
  import mode_map_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h7FFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              xram_en,
  output logic [SEL_W-1:0]  sel
);
  always_comb begin
    sel = '0;
    if (addr <= RAM_TOP) sel[SEL_LOCAL] = 1'b1;
    else if (xram_en)    sel[SEL_MID]   = 1'b1;
    else                 sel[SEL_EXT]   = 1'b1;
  end
endmodule

// File: rtl/addr_vis.sv
module addr_vis #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              vis_en,
  input  logic [ADDR_W-1:0] pgm_addr,
  output logic [ADDR_W-1:0] ext_addr
);
  always_ff @(posedge clk) begin
    if (hw_rst)      ext_addr <= '0;
    else if (vis_en) ext_addr <= pgm_addr;
  end

  // R10
  ext_hold_chk: assert property (@(posedge clk) disable iff (hw_rst)
    !vis_en |=> $stable(ext_addr));

  // R10
  ext_follow_chk: assert property (@(posedge clk) disable iff (hw_rst)
    vis_en |=> ext_addr == $past(pgm_addr));
endmodule

// File: rtl/mode_map_top.sv
module mode_map_top
  import mode_map_pkg::*;
#(
  parameter logic [WORD_W-1:0] ROM_BASE  = 16'hC000,
  parameter logic [WORD_W-1:0] PAGE0_TOP = 16'h007F,
  parameter logic [WORD_W-1:0] RAM_TOP   = 16'h7FFF
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              soft_rst,
  input  logic              mode_pin,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic [WORD_W-1:0] pgm_addr,
  input  logic [WORD_W-1:0] data_addr,
  output logic [SEL_W-1:0]  pgm_sel,
  output logic [SEL_W-1:0]  dat_sel,
  input  logic [INT_W-1:0]  int_num,
  output logic [WORD_W-1:0] vec_addr,
  output logic              clk_out,
  output logic [WORD_W-1:0] ext_addr
);
  mode_t mode_q;

  mode_reg u_reg (
    .clk(clk), .hw_rst(hw_rst), .soft_rst(soft_rst), .mode_pin(mode_pin),
    .wr_en(wr_en), .wr_data(wr_data), .q(mode_q)
  );

  assign rd_data = mode_q;

  prog_decode #(
    .ADDR_W(WORD_W), .ROM_BASE(ROM_BASE), .PAGE0_TOP(PAGE0_TOP), .OVL_TOP(RAM_TOP)
  ) u_pdec (
    .addr(pgm_addr), .ext_boot(mode_q.ext_boot), .ovl_en(mode_q.ovl_en), .sel(pgm_sel)
  );

  data_decode #(.ADDR_W(WORD_W), .RAM_TOP(RAM_TOP)) u_ddec (
    .addr(data_addr), .xram_en(mode_q.xram_en), .sel(dat_sel)
  );

  addr_vis #(.ADDR_W(WORD_W)) u_vis (
    .clk(clk), .hw_rst(hw_rst), .vis_en(mode_q.addr_vis),
    .pgm_addr(pgm_addr), .ext_addr(ext_addr)
  );

  assign vec_addr = {mode_q.vec_page, int_num, {SLOT_BITS{1'b0}}};
  assign clk_out  = clk | mode_q.clk_hold;

  // R8
  pgm_onehot_chk: assert property (@(posedge clk) disable iff (hw_rst)
    $countones(pgm_sel) == 1);

  // R8
  dat_onehot_chk: assert property (@(posedge clk) disable iff (hw_rst)
    $countones(dat_sel) == 1);

  // R6
  page0_excl_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (pgm_addr <= PAGE0_TOP) |-> !pgm_sel[SEL_LOCAL]);

  // R5
  rom_gate_chk: assert property (@(posedge clk) disable iff (hw_rst)
    mode_q.ext_boot |-> !pgm_sel[SEL_MID]);
endmodule

// File: tb/mode_map_top_tb_top.sv
module mode_map_top_tb_top;
  logic        clk = 1'b0;
  logic        hw_rst = 1'b1, soft_rst = 1'b0, mode_pin = 1'b1, wr_en = 1'b0;
  logic [15:0] wr_data = '0, pgm_addr = '0, data_addr = '0;
  logic [4:0]  int_num = '0;
  logic [15:0] rd_data, vec_addr, ext_addr;
  logic [2:0]  pgm_sel, dat_sel;
  logic        clk_out;
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  mode_map_top dut_i (
    .clk(clk), .hw_rst(hw_rst), .soft_rst(soft_rst), .mode_pin(mode_pin),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pgm_addr(pgm_addr), .data_addr(data_addr), .pgm_sel(pgm_sel), .dat_sel(dat_sel),
    .int_num(int_num), .vec_addr(vec_addr), .clk_out(clk_out), .ext_addr(ext_addr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hreset(input logic pin);
    @(negedge clk); hw_rst = 1'b1; mode_pin = pin;
    @(negedge clk); hw_rst = 1'b0;
  endtask

  function automatic logic [2:0] exp_p(input int a, input bit ext, input bit ovl);
    if (ovl && a >= 'h80 && a <= 'h7FFF) return 3'b001;
    if (!ext && a >= 'hC000) return 3'b010;
    return 3'b100;
  endfunction

  function automatic logic [2:0] exp_d(input int a, input bit xr);
    if (a <= 'h7FFF) return 3'b001;
    return xr ? 3'b010 : 3'b100;
  endfunction

  task automatic dec_at(input int a, input bit ext, input bit ovl, input bit xr);
    pgm_addr = a[15:0]; data_addr = a[15:0]; #1;
    chk("R5/R6/R8 pgm_sel", {13'd0, pgm_sel}, {13'd0, exp_p(a, ext, ovl)});
    chk("R7/R8 dat_sel",   {13'd0, dat_sel}, {13'd0, exp_d(a, xr)});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    // R1: reset with pin high
    repeat (2) @(negedge clk);
    chk("R1 reset word pin=1", rd_data, 16'hFFC0);
    int_num = 5'd0; #1;
    chk("R1 reset vector", vec_addr, 16'hFF80);
    hw_rst = 1'b0;
    // R4: pin ignored outside reset
    mode_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 pin ignored", rd_data, 16'hFFC0);
    wr(16'hFF80);
    chk("R4 sw clears bit6", rd_data, 16'hFF80);
    mode_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 pin still ignored", rd_data, 16'hFF80);
    wr(16'hFFC0);
    chk("R4 sw sets bit6", rd_data, 16'hFFC0);
    hreset(1'b0);
    chk("R1 reset word pin=0", rd_data, 16'hFF80);
    hreset(1'b1);
    chk("R1 reset word pin=1 again", rd_data, 16'hFFC0);
    // R2: full-width readback
    wr(16'h123F); chk("R2 readback", rd_data, 16'h123F);
    wr(16'hA5C1); chk("R2 readback", rd_data, 16'hA5C1);
    // R3: soft reset
    wr(16'h127F);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R3 soft reset", rd_data, 16'h1240);
    wr(16'h0FBF);
    @(negedge clk); soft_rst = 1'b1; wr_en = 1'b1; wr_data = 16'hFFFF;
    @(negedge clk); soft_rst = 1'b0; wr_en = 1'b0;
    chk("R3 soft beats write", rd_data, 16'h0F80);
    @(negedge clk); soft_rst = 1'b1; hw_rst = 1'b1; mode_pin = 1'b0;
    @(negedge clk); soft_rst = 1'b0; hw_rst = 1'b0;
    chk("R3 hw beats soft", rd_data, 16'hFF80);
    // R11: vector sweep
    foreach (w[i]) ; // no-op to keep w declared usage simple
    for (int p = 0; p < 4; p++) begin
      logic [8:0] pg;
      pg = (p == 0) ? 9'h000 : (p == 1) ? 9'h1FF : (p == 2) ? 9'h0AA : 9'h155;
      wr({pg, 7'h00});
      for (int n = 0; n < 32; n++) begin
        int_num = n[4:0]; #1;
        chk("R11 vector", vec_addr, 16'(pg * 128 + n * 4));
      end
    end
    // R5-R8: decode sweep over every mode combination
    for (int m = 0; m < 8; m++) begin
      bit e, o, x;
      e = m[0]; o = m[1]; x = m[2];
      w = {9'h1FF, e, o, 1'b0, x, 3'b000};
      wr(w);
      chk("R2 mode write", rd_data, w);
      for (int a = 0; a < 65536; a += 61) dec_at(a, e, o, x);
      dec_at('h0000, e, o, x); dec_at('h007F, e, o, x); dec_at('h0080, e, o, x);
      dec_at('h7FFF, e, o, x); dec_at('h8000, e, o, x); dec_at('hBFFF, e, o, x);
      dec_at('hC000, e, o, x); dec_at('hFFFF, e, o, x);
    end
    // R9: clock hold
    wr(16'h0004);
    @(negedge clk); #1;
    chk("R9 clk held high", {15'd0, clk_out}, 16'd1);
    wr(16'h0000);
    @(negedge clk); #1;
    chk("R9 clk low phase", {15'd0, clk_out}, 16'd0);
    @(posedge clk); #1;
    chk("R9 clk high phase", {15'd0, clk_out}, 16'd1);
    // R10: address visibility
    @(negedge clk); pgm_addr = 16'h3C3C;
    repeat (2) @(negedge clk);
    chk("R10 hold while off", ext_addr, 16'h0000);
    wr(16'h0010);
    @(negedge clk); pgm_addr = 16'hBEEF;
    @(negedge clk);
    chk("R10 follow", ext_addr, 16'hBEEF);
    pgm_addr = 16'h1234;
    @(negedge clk);
    chk("R10 follow next", ext_addr, 16'h1234);
    wr(16'h0000);
    pgm_addr = 16'h5555;
    repeat (3) @(negedge clk);
    chk("R10 hold last", ext_addr, 16'h1234);
    hreset(1'b1);
    chk("R10 reset clears", ext_addr, 16'h0000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule